// File: doc/BRIEF.md
# Slotted-Page Attribute Fetcher

This block pulls one attribute out of each requested record on a slotted data page in external memory. A page holds a header word with the slot count, then an array of slot entries. Each slot entry gives the byte offset of a record from the page base. The caller presents a page base address, a fixed-length or variable-length mode, and a stream of record indices, one at a time. For each index the block finds the record, locates the attribute and streams the attribute out as a burst of data beats. It then pulses a done flag.

The first request that names a page copies the page's slot array into a small local buffer. Later requests on the same page look the slot up locally and skip that external read. In variable-length mode the record header is read to find the attribute offset. In fixed-length mode the attribute sits at a constant offset inside the record. External memory is reached through a simple request/response port, and the block keeps only one request in flight on it.

Top module: `spf_attr_fetch`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_req_valid`, `out_valid`, `out_last` and `done` are 0. The slot buffer is treated as empty, so the first request after any reset reloads its page.
- R2: On a page that is not buffered, the first memory access is a single-word read at the page base. The low 16 bits of that word are the slot count. Next come one single-word read per slot, in ascending order, at base+4+4k. The low 16 bits of each returned word are the record's byte offset from the base.
- R3: A request on the page that is already buffered issues no page-header read and no slot read.
- R4: In fixed-length mode (`var_mode`=0), the block issues one burst read (`mem_req_burst`=1, returning 16 consecutive 32-bit words) at base+slot offset+8. The returned words appear on `out_data` in arrival order.
- R5: In variable-length mode (`var_mode`=1), the block first makes a single-word read of the record header at base+slot offset. The low 16 bits of the header are the attribute offset inside the record. The burst read then goes to base+slot offset+that offset.
- R6: `out_last` marks the 16th beat of an attribute. `done` is high in that same cycle and lasts exactly one cycle.
- R7: An index equal to or above the page's slot count ends with `done` and no data beats. Apart from any reload of the page, it makes no memory access.
- R8: A request whose page base differs from the buffered page reloads the header and the slot array before the lookup.
- R9: A new memory request is issued only after every response word of the previous request has arrived.
- R10: A slot count above 16 is clamped to 16. Only 16 slots are loaded, and index 16 or above is treated as out of range.
- R11: `req_ready` falls in the cycle after a request is accepted and stays low until the request's `done` cycle has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page_base | input | 12 | Byte address of the page, sampled with the request |
| var_mode | input | 1 | 1 = variable-length records, 0 = fixed-length |
| req_valid | input | 1 | Record request present |
| req_idx | input | 8 | Record (slot) index on the page |
| req_ready | output | 1 | Block idle and able to take a request |
| mem_req_valid | output | 1 | One-cycle memory request strobe |
| mem_req_addr | output | 12 | Byte address of the memory request |
| mem_req_burst | output | 1 | 1 = 16-word burst, 0 = single word |
| mem_rsp_valid | input | 1 | Memory response word valid |
| mem_rsp_data | input | 32 | Memory response word |
| out_valid | output | 1 | Attribute data beat valid |
| out_data | output | 32 | Attribute data beat |
| out_last | output | 1 | Final beat of the attribute |
| done | output | 1 | Request finished (one cycle) |

## Verification
The bench walks four pages in a sequence that mixes buffered hits, page switches, a return to an earlier page, an oversized slot count and an empty page. It compares the logged memory requests against the expected sequence. A block that never buffered the slot array would show extra header and slot reads on repeated requests. A block that kept stale slots after a page switch would fetch from the wrong addresses. Out-of-range indices must finish with no beats. A design that compared against the raw count instead of the clamped count would read past its buffer at index 16. A mode mix-up would either skip the record-header read or burst from the wrong offset. The bench also repeats a request after a mid-run reset, to catch a slot buffer that survives reset.

// File: rtl/spf_pkg.sv
package spf_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_PGHDR = 3'd1,
        S_SLOT  = 3'd2,
        S_LOOK  = 3'd3,
        S_RHDR  = 3'd4,
        S_ATTR  = 3'd5,
        S_DONE  = 3'd6
    } fetch_st_e;
endpackage

// File: rtl/spf_slot_buf.sv
module spf_slot_buf #(
    parameter int DEPTH = 16,
    parameter int EW    = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_addr,
    input  logic [EW-1:0] wr_data,
    input  logic [IW-1:0] rd_addr,
    output logic [EW-1:0] rd_data
);
    logic [EW-1:0] ent_q [DEPTH];

    // one register per slot entry, written only when its index is addressed
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr == IW'(g))) begin
                ent_q[g] <= wr_data;
            end
        end
    end

    assign rd_data = ent_q[rd_addr];
endmodule

// File: rtl/spf_addr_gen.sv
module spf_addr_gen
    import spf_pkg::*;
#(
    parameter int AW        = 12,
    parameter int SW        = 4,
    parameter int SLOT_BASE = 4
) (
    input  fetch_st_e     state,
    input  logic [AW-1:0] base,
    input  logic [SW-1:0] ld_k,
    input  logic [15:0]   rec_off,
    input  logic [15:0]   a_off,
    output logic [AW-1:0] addr,
    output logic          burst
);
    always_comb begin
        addr  = base;
        burst = 1'b0;
        case (state)
            S_SLOT:  addr = base + AW'(SLOT_BASE) + AW'({ld_k, 2'b00});
            S_RHDR:  addr = base + AW'(rec_off);
            S_ATTR: begin
                addr  = base + AW'(rec_off) + AW'(a_off);
                burst = 1'b1;
            end
            default: addr = base;
        endcase
    end
endmodule

// File: rtl/spf_attr_fetch.sv
module spf_attr_fetch
    import spf_pkg::*;
#(
    parameter int AW        = 12,
    parameter int DW        = 32,
    parameter int IDXW      = 8,
    parameter int MAX_SLOTS = 16,
    parameter int BEATS     = 16,
    parameter int ATTR_OFS  = 8,
    parameter int SLOT_BASE = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   page_base,
    input  logic            var_mode,
    input  logic            req_valid,
    input  logic [IDXW-1:0] req_idx,
    output logic            req_ready,
    output logic            mem_req_valid,
    output logic [AW-1:0]   mem_req_addr,
    output logic            mem_req_burst,
    input  logic            mem_rsp_valid,
    input  logic [DW-1:0]   mem_rsp_data,
    output logic            out_valid,
    output logic [DW-1:0]   out_data,
    output logic            out_last,
    output logic            done
);
    localparam int SW = $clog2(MAX_SLOTS);
    localparam int CW = $clog2(MAX_SLOTS + 1);
    localparam int BW = $clog2(BEATS);
    localparam logic [15:0] MAX16 = 16'(MAX_SLOTS);

    typedef struct packed {
        fetch_st_e       st;
        logic            issued;
        logic [AW-1:0]   base;
        logic            vmode;
        logic [IDXW-1:0] idx;
        logic [CW-1:0]   cnt;
        logic [SW-1:0]   ld_k;
        logic            cvld;
        logic [AW-1:0]   cbase;
        logic [15:0]     rec_off;
        logic [15:0]     a_off;
        logic [BW-1:0]   beat;
        logic            ov;
        logic [DW-1:0]   od;
        logic            ol;
    } regs_t;

    regs_t q, d;

    logic          buf_we;
    logic [15:0]   buf_rd;
    logic          wait_st;
    logic [15:0]   rsp_lo;

    assign rsp_lo  = mem_rsp_data[15:0];
    assign wait_st = (q.st == S_PGHDR) || (q.st == S_SLOT) ||
                     (q.st == S_RHDR)  || (q.st == S_ATTR);

    spf_slot_buf #(.DEPTH(MAX_SLOTS), .EW(16)) slot_buf_i (
        .clk     (clk),
        .wr_en   (buf_we),
        .wr_addr (q.ld_k),
        .wr_data (rsp_lo),
        .rd_addr (q.idx[SW-1:0]),
        .rd_data (buf_rd)
    );

    spf_addr_gen #(.AW(AW), .SW(SW), .SLOT_BASE(SLOT_BASE)) addr_gen_i (
        .state   (q.st),
        .base    (q.base),
        .ld_k    (q.ld_k),
        .rec_off (q.rec_off),
        .a_off   (q.a_off),
        .addr    (mem_req_addr),
        .burst   (mem_req_burst)
    );

    always_comb begin
        d             = q;
        d.ov          = 1'b0;
        d.ol          = 1'b0;
        buf_we        = 1'b0;
        mem_req_valid = wait_st && !q.issued;
        if (mem_req_valid) begin
            d.issued = 1'b1;
        end
        case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.base   = page_base;
                    d.vmode  = var_mode;
                    d.idx    = req_idx;
                    d.issued = 1'b0;
                    if (q.cvld && (page_base == q.cbase)) begin
                        d.st = S_LOOK;
                    end else begin
                        d.cvld = 1'b0;
                        d.st   = S_PGHDR;
                    end
                end
            end
            S_PGHDR: begin
                if (mem_rsp_valid) begin
                    d.cnt    = (rsp_lo > MAX16) ? CW'(MAX_SLOTS) : CW'(rsp_lo);
                    d.ld_k   = '0;
                    d.cbase  = q.base;
                    d.issued = 1'b0;
                    if (rsp_lo == 16'd0) begin
                        d.cvld = 1'b1;
                        d.st   = S_LOOK;
                    end else begin
                        d.st = S_SLOT;
                    end
                end
            end
            S_SLOT: begin
                if (mem_rsp_valid) begin
                    buf_we   = 1'b1;
                    d.issued = 1'b0;
                    if ((CW'(q.ld_k) + CW'(1)) == q.cnt) begin
                        d.cvld = 1'b1;
                        d.st   = S_LOOK;
                    end else begin
                        d.ld_k = q.ld_k + 1'b1;
                    end
                end
            end
            S_LOOK: begin
                if (q.idx >= IDXW'(q.cnt)) begin
                    d.st = S_DONE;
                end else begin
                    d.rec_off = buf_rd;
                    d.a_off   = 16'(ATTR_OFS);
                    d.beat    = '0;
                    d.issued  = 1'b0;
                    d.st      = q.vmode ? S_RHDR : S_ATTR;
                end
            end
            S_RHDR: begin
                if (mem_rsp_valid) begin
                    d.a_off  = rsp_lo;
                    d.issued = 1'b0;
                    d.st     = S_ATTR;
                end
            end
            S_ATTR: begin
                if (mem_rsp_valid) begin
                    d.ov   = 1'b1;
                    d.od   = mem_rsp_data;
                    d.beat = q.beat + 1'b1;
                    if (q.beat == BW'(BEATS - 1)) begin
                        d.ol = 1'b1;
                        d.st = S_DONE;
                    end
                end
            end
            S_DONE:  d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == S_IDLE);
    assign done      = (q.st == S_DONE);
    assign out_valid = q.ov;
    assign out_data  = q.od;
    assign out_last  = q.ol;
endmodule

// File: rtl/spf_attr_fetch_chk.sv
module spf_attr_fetch_chk #(
    parameter int BEATS = 16
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic mem_req_valid,
    input logic mem_req_burst,
    input logic mem_rsp_valid,
    input logic out_valid,
    input logic out_last,
    input logic done
);
    logic [15:0] left_q;
    logic [15:0] bc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            bc_q   <= '0;
        end else begin
            if (mem_req_valid) begin
                left_q <= mem_req_burst ? 16'(BEATS) : 16'd1;
            end else if (mem_rsp_valid && (left_q != 16'd0)) begin
                left_q <= left_q - 16'd1;
            end
            if (done) begin
                bc_q <= '0;
            end else if (out_valid) begin
                bc_q <= bc_q + 16'd1;
            end
        end
    end

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (left_q == 16'd0)); // R9
    AST_LAST_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (done && out_valid)); // R6
    AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (bc_q == 16'(BEATS - 1))); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R11
    AST_BEAT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !req_ready); // R4
endmodule

bind spf_attr_fetch spf_attr_fetch_chk #(.BEATS(BEATS)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_burst (mem_req_burst),
    .mem_rsp_valid (mem_rsp_valid),
    .out_valid     (out_valid),
    .out_last      (out_last),
    .done          (done)
);

// File: tb/spf_attr_fetch_tb_top.sv
`timescale 1ns/1ps
module spf_attr_fetch_tb_top;
    localparam int LAT = 3;
    localparam int NV  = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] page_base = '0;
    logic        var_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_idx = '0;
    logic        req_ready;
    logic        mem_req_valid;
    logic [11:0] mem_req_addr;
    logic        mem_req_burst;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_last;
    logic        done;

    always #4 clk = ~clk;

    spf_attr_fetch dut_i (
        .clk(clk), .rst_n(rst_n), .page_base(page_base), .var_mode(var_mode),
        .req_valid(req_valid), .req_idx(req_idx), .req_ready(req_ready),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_burst(mem_req_burst), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .done(done)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory model and page contents
    logic [31:0] mem [1024];
    int pg_base [4] = '{'h000, 'h400, 'h800, 'hC00};
    int pg_cnt  [4] = '{5, 3, 40, 0};

    function automatic int off_of(int k);
        return 'h100 + 'h18 * k;
    endfunction
    function automatic int hdr_of(int p, int k);
        return 'h08 + 4 * ((k + p) % 5);
    endfunction

    bit mbusy = 1'b0;
    int mwait = 0;
    int mword = 0;
    int mleft = 0;
    int log_n = 0;
    int log_a [64];
    bit log_b [64];

    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (mbusy) begin
            if (mem_req_valid) chk(1'b0, "R9", "request while busy", 1, 0);
            if (mwait > 0) begin
                mwait--;
            end else begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem[mword];
                mword++;
                mleft--;
                if (mleft == 0) mbusy = 1'b0;
            end
        end else if (mem_req_valid) begin
            mbusy = 1'b1;
            mwait = LAT;
            mword = int'(mem_req_addr[11:2]);
            mleft = mem_req_burst ? 16 : 1;
            if (log_n < 64) begin
                log_a[log_n] = int'(mem_req_addr);
                log_b[log_n] = mem_req_burst;
            end
            log_n++;
        end
    end

    // bench model of the page buffer
    bit bc_vld = 1'b0;
    int bc_p = 0;

    task automatic run_one(input int p, input bit vm, input int idx);
        int nload, exp_reqs, base, attr, nb, bad_data, last_at, t, slot_bad;
        bit miss, hit_rng, lw_done;
        string rq;
        base    = pg_base[p];
        nload   = (pg_cnt[p] > 16) ? 16 : pg_cnt[p];
        miss    = !(bc_vld && bc_p == p);
        hit_rng = (idx < nload);
        exp_reqs = (miss ? 1 + nload : 0) + (hit_rng ? (vm ? 2 : 1) : 0);
        attr    = base + off_of(idx) + (vm ? hdr_of(p, idx) : 8);
        bc_vld  = 1'b1;
        bc_p    = p;
        @(negedge clk);
        chk(req_ready == 1'b1, "R11", "ready before request", req_ready, 1);
        log_n     = 0;
        page_base = 12'(base);
        var_mode  = vm;
        req_idx   = 8'(idx);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R11", "ready after accept", req_ready, 0);
        nb = 0; bad_data = 0; last_at = -1; lw_done = 1'b0; t = 0;
        forever begin
            if (out_valid) begin
                if (nb < 16 && out_data != mem[(attr >> 2) + nb]) bad_data++;
                if (out_last) last_at = nb;
                nb++;
            end
            if (done) begin
                lw_done = out_last;
                break;
            end
            if (t > 2000) break;
            t++;
            @(negedge clk);
        end
        rq = !hit_rng ? "R7" : (miss ? "R2" : "R3");
        chk(done == 1'b1, rq, "done seen", done, 1);
        chk(log_n == exp_reqs, rq, "memory request count", log_n, exp_reqs);
        if (miss) begin
            chk(log_a[0] == base && !log_b[0], "R8", "page header read addr", log_a[0], base);
            slot_bad = 0;
            for (int k = 0; k < nload; k++)
                if (log_a[1 + k] != base + 4 + 4 * k || log_b[1 + k]) slot_bad++;
            chk(slot_bad == 0, (p == 2) ? "R10" : "R2", "slot read addrs", slot_bad, 0);
        end
        if (hit_rng) begin
            chk(log_a[log_n - 1] == attr && log_b[log_n - 1], vm ? "R5" : "R4",
                "attribute burst addr", log_a[log_n - 1], attr);
            if (vm)
                chk(log_a[log_n - 2] == base + off_of(idx) && !log_b[log_n - 2], "R5",
                    "record header addr", log_a[log_n - 2], base + off_of(idx));
            chk(bad_data == 0, "R4", "beat data mismatches", bad_data, 0);
            chk(nb == 16, "R6", "beat count", nb, 16);
            chk(last_at == 15 && lw_done, "R6", "last beat with done", last_at, 15);
        end else begin
            chk(nb == 0, "R7", "beats on out-of-range index", nb, 0);
        end
        @(negedge clk);
        chk(done == 1'b0, "R6", "done one cycle", done, 0);
    endtask

    // {page[1:0], var_mode, idx[7:0]}
    localparam logic [10:0] VEC [NV] = '{
        {2'd0, 1'b0, 8'd0},  {2'd0, 1'b0, 8'd3},  {2'd0, 1'b1, 8'd1},
        {2'd0, 1'b1, 8'd4},  {2'd0, 1'b0, 8'd5},  {2'd1, 1'b1, 8'd2},
        {2'd1, 1'b0, 8'd0},  {2'd0, 1'b1, 8'd2},  {2'd2, 1'b0, 8'd15},
        {2'd2, 1'b0, 8'd16}, {2'd3, 1'b0, 8'd0},  {2'd3, 1'b1, 8'd3}
    };

    initial begin
        for (int w = 0; w < 1024; w++) mem[w] = 32'hC0DE0000 ^ (32'(w) * 32'h00010003);
        for (int p = 0; p < 4; p++) begin
            mem[pg_base[p] >> 2] = 32'hAB000000 | 32'(pg_cnt[p]);
            for (int k = 0; k < pg_cnt[p]; k++)
                mem[(pg_base[p] >> 2) + 1 + k] = 32'h55550000 | 32'(off_of(k));
            for (int k = 0; k < 16; k++)
                mem[(pg_base[p] + off_of(k)) >> 2] = 32'h77770000 | 32'(hdr_of(p, k));
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !mem_req_valid && !out_valid && !out_last && !done, "R1",
            "reset outputs", {req_ready, mem_req_valid, out_valid, done}, 4'b1000);
        for (int i = 0; i < NV; i++)
            run_one(int'(VEC[i][10:9]), VEC[i][8], int'(VEC[i][7:0]));
        // reset must drop the buffered page: same page again reloads (R1)
        run_one(1, 1'b0, 1);
        run_one(1, 1'b0, 2);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        bc_vld = 1'b0;
        chk(req_ready && !out_valid && !done, "R1", "outputs after mid-run reset",
            {req_ready, out_valid, done}, 3'b100);
        run_one(1, 1'b0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule